// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master Sequencer

The block moves single read and write transfers from an on-chip requester onto a shared external bus. The bus carries address and data on one set of lines, time-multiplexed. Ownership of the bus is negotiated with an outside arbiter through a hold request (`bus_hold`) and a hold acknowledge (`bus_hlda`). Once the grant is seen, the block drives a latch strobe for the address, byte enables, and active-low read and write strobes. It also steers the address/data lines through separate output-enable pins that control pad buffers outside the block. A transfer ends with a one-cycle response that carries read data, or that reports the transfer was dropped because the grant was withdrawn mid-transfer. A dropped transfer is never retried.

The requester side is a valid/ready stream of width one transfer. `req_ready` is high only while the sequencer is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high, and the request fields need only be valid in that cycle. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and the requester must take it when it appears. Because only one transfer is ever in flight, the response cannot collide with the next request.

Three lapse counts stretch the timing, each giving a minimum timing at zero. One stretches the address-latch phase, one stretches the strobe phase, and one stretches the idle gap between bus requests. All three counts are taken with the request. After a transfer finishes normally, the bus is parked: the command pins stay driven at their inactive levels and the address/data lines float. The park lasts until the arbiter drops the acknowledge, or until the next transfer takes over.

Top module: `extbus_master`

## Requirements
- R1: While reset is asserted and right after it, `bus_hold`, `bus_cmd_oe`, `bus_ad_oe` and `rsp_valid` are low and `req_ready` is high.
- R2: A request is accepted only when `req_ready` is high. `bus_hold` rises in the cycle after acceptance. `req_ready` stays low from then until the gap of R11 has elapsed, and `req_ready` is never high while `bus_hold` is high.
- R3: Call E0 the first clock edge at which `bus_hold` and `bus_hlda` are both high. After E0, `bus_cmd_oe` is high and `bus_be` shows the request's byte enables. After E0+1, `bus_ad_oe` is high with the address on `bus_ad_out`. After E0+2, `bus_ale` is high, and it stays high for 1 + address-lapse cycles. No bus output is enabled by the transfer before E0.
- R4: In the cycle after `bus_ale` falls, the address is still driven on `bus_ad_out`.
- R5: On a write, the write data is driven for exactly one cycle before `bus_wr_n` goes low. `bus_wr_n` stays low for 1 + strobe-lapse cycles. The write data and byte enables stay driven for one cycle after `bus_wr_n` returns high. At most one of `bus_rd_n` and `bus_wr_n` is low at any time.
- R6: On a read, `bus_rd_n` stays low for 1 + strobe-lapse cycles and `bus_ad_oe` is low throughout. The value returned in `rsp_rdata` is `bus_ad_in` as sampled at the clock edge that ends the last low cycle of `bus_rd_n`.
- R7: One cycle after the strobe returns high, `bus_hold` falls and the bus is parked. Parked means `bus_cmd_oe` high, `bus_ale` low, both strobes high, `bus_be` zero and `bus_ad_oe` low. In that same cycle `rsp_valid` pulses with `rsp_abort` low.
- R8: The park ends with `bus_cmd_oe` low one cycle after `bus_hlda` is sampled low. If `bus_hlda` stays high until the next request, `bus_cmd_oe` stays high without a break into that transfer's command phase.
- R9: Whenever `bus_hold` is low and `bus_hlda` has been low at the current and the previous clock edge, `bus_cmd_oe` and `bus_ad_oe` are low.
- R10: If `bus_hlda` is sampled low at any edge from E0 until the transfer completes, then in the next cycle `bus_hold`, `bus_cmd_oe` and `bus_ad_oe` are low and `rsp_valid` pulses with `rsp_abort` high. `bus_hold` stays low afterwards until a new request is accepted.
- R11: After `bus_hold` falls, `req_ready` stays low for 1 + gap-lapse cycles and then rises.
- R12: The three lapse counts are taken only at acceptance, and changing them during a transfer has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AD_W | Transfer address |
| req_be | input | AD_W/8 | Byte enables of the transfer |
| req_wdata | input | AD_W | Write data |
| cfg_addr_lapse | input | LAPSE_W | Extra address-latch cycles |
| cfg_strobe_lapse | input | LAPSE_W | Extra strobe-low cycles |
| cfg_gap_lapse | input | LAPSE_W | Extra cycles between bus requests |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_abort | output | 1 | Completion was a dropped transfer |
| rsp_rdata | output | AD_W | Read data of the completed read |
| bus_hold | output | 1 | Bus request to the arbiter |
| bus_hlda | input | 1 | Bus grant from the arbiter |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_be | output | AD_W/8 | Byte enables |
| bus_cmd_oe | output | 1 | Enable for ale, strobes and byte enables |
| bus_ad_out | output | AD_W | Address/data value to drive |
| bus_ad_oe | output | 1 | Enable for the address/data lines |
| bus_ad_in | input | AD_W | Address/data value from the pads |

## Verification
The bench builds the block with its defaults: a 32-bit address/data path, four byte enables and 4-bit lapse counts. This makes every lapse count from 0 to 15 reachable, so directed cases cover both the all-zero minimum timing and the all-fifteen maximum stretch. Random transfers mix reads and writes, grant delays, withdrawals of the grant in every phase including the command cycle, and early or late release of the park. A fixed seed keeps runs repeatable.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_CMD,
    ST_ADDR,
    ST_ALE,
    ST_AHOLD,
    ST_WLEAD,
    ST_STROBE,
    ST_TAIL,
    ST_GAP
  } bus_state_e;

  // States in which the transfer owns the bus and loses it if the grant drops.
  function automatic logic in_transfer(bus_state_e s);
    return s inside {ST_CMD, ST_ADDR, ST_ALE, ST_AHOLD, ST_WLEAD, ST_STROBE, ST_TAIL};
  endfunction

  function automatic logic address_phase(bus_state_e s);
    return s inside {ST_ADDR, ST_ALE, ST_AHOLD};
  endfunction

  function automatic logic wdata_phase(bus_state_e s);
    return s inside {ST_WLEAD, ST_STROBE, ST_TAIL};
  endfunction

endpackage

// File: rtl/extbus_lapse_timer.sv
module extbus_lapse_timer #(
  parameter int LAPSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LAPSE_W-1:0] load_val,
  output logic               expired
);

  logic [LAPSE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int LAPSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [LAPSE_W-1:0] cfg_addr_lapse,
  input  logic [LAPSE_W-1:0] cfg_strobe_lapse,
  input  logic [LAPSE_W-1:0] cfg_gap_lapse,
  input  logic               hlda_i,
  output logic               req_ready,
  output logic               accept_o,
  output logic               capture_o,
  output logic               write_o,
  output logic               park_o,
  output bus_state_e         state_o,
  output logic               rsp_valid_o,
  output logic               rsp_abort_o
);

  bus_state_e         state_q, state_d;
  logic               write_q;
  logic [LAPSE_W-1:0] alapse_q, slapse_q, glapse_q;
  logic               park_q;
  logic               rsp_valid_q, rsp_abort_q;
  logic               tmr_load, tmr_zero;
  logic [LAPSE_W-1:0] tmr_val;
  logic               done_ok, lost;

  assign accept_o = (state_q == ST_IDLE) && req_valid;

  extbus_lapse_timer #(.LAPSE_W(LAPSE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    done_ok   = 1'b0;
    lost      = 1'b0;
    capture_o = 1'b0;
    if (in_transfer(state_q) && !hlda_i) begin
      lost     = 1'b1;
      state_d  = ST_GAP;
      tmr_load = 1'b1;
      tmr_val  = glapse_q;
    end else begin
      case (state_q)
        ST_IDLE:  if (req_valid) state_d = ST_REQ;
        ST_REQ:   if (hlda_i) state_d = ST_CMD;
        ST_CMD:   state_d = ST_ADDR;
        ST_ADDR: begin
          state_d  = ST_ALE;
          tmr_load = 1'b1;
          tmr_val  = alapse_q;
        end
        ST_ALE:   if (tmr_zero) state_d = ST_AHOLD;
        ST_AHOLD: begin
          if (write_q) begin
            state_d = ST_WLEAD;
          end else begin
            state_d  = ST_STROBE;
            tmr_load = 1'b1;
            tmr_val  = slapse_q;
          end
        end
        ST_WLEAD: begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = slapse_q;
        end
        ST_STROBE: begin
          if (tmr_zero) begin
            state_d   = ST_TAIL;
            capture_o = !write_q;
          end
        end
        ST_TAIL: begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = glapse_q;
          done_ok  = 1'b1;
        end
        ST_GAP:   if (tmr_zero) state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      write_q     <= 1'b0;
      alapse_q    <= '0;
      slapse_q    <= '0;
      glapse_q    <= '0;
      park_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        write_q  <= req_write;
        alapse_q <= cfg_addr_lapse;
        slapse_q <= cfg_strobe_lapse;
        glapse_q <= cfg_gap_lapse;
      end
      if (done_ok) begin
        park_q <= 1'b1;
      end else if (!hlda_i || (state_q == ST_REQ)) begin
        park_q <= 1'b0;
      end
      rsp_valid_q <= done_ok || lost;
      rsp_abort_q <= lost;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign write_o     = write_q;
  assign park_o      = park_q;
  assign state_o     = state_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_abort_o = rsp_abort_q;

  // R12: the sampled counts never move while a transfer is under way
  a_r12_lapse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(alapse_q) && $stable(slapse_q) && $stable(glapse_q)));

  // R11: leaving the gap is only possible once the timer has run out
  a_r11_gap_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP && !tmr_zero) |=> (state_q == ST_GAP));

endmodule

// File: rtl/extbus_pins.sv
module extbus_pins
  import extbus_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            capture,
  input  logic            write_q,
  input  logic            park,
  input  bus_state_e      state,
  input  logic [AD_W-1:0] req_addr,
  input  logic [BE_W-1:0] req_be,
  input  logic [AD_W-1:0] req_wdata,
  input  logic [AD_W-1:0] bus_ad_in,
  output logic            bus_hold,
  output logic            bus_cmd_oe,
  output logic            bus_ale,
  output logic            bus_rd_n,
  output logic            bus_wr_n,
  output logic [BE_W-1:0] bus_be,
  output logic [AD_W-1:0] bus_ad_out,
  output logic            bus_ad_oe,
  output logic [AD_W-1:0] rdata
);

  logic [AD_W-1:0] addr_q, wdata_q, rdata_q;
  logic [BE_W-1:0] be_q;
  logic            xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (capture) begin
        rdata_q <= bus_ad_in;
      end
    end
  end

  assign xfer       = in_transfer(state);
  assign bus_hold   = (state == ST_REQ) || xfer;
  assign bus_cmd_oe = xfer || park;
  assign bus_be     = xfer ? be_q : '0;
  assign bus_ale    = (state == ST_ALE);
  assign bus_rd_n   = !((state == ST_STROBE) && !write_q);
  assign bus_wr_n   = !((state == ST_STROBE) && write_q);
  assign bus_ad_oe  = address_phase(state) || (write_q && wdata_phase(state));
  assign bus_ad_out = address_phase(state) ? addr_q : wdata_q;
  assign rdata      = rdata_q;

  // R6: the lines are released whenever the read strobe is active
  a_r6_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);

  // R5: never both strobes at once
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R3: the latch strobe only appears with command and address driven
  a_r3_ale_driven: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_cmd_oe && bus_ad_oe && bus_hold));

endmodule

// File: rtl/extbus_master.sv
module extbus_master #(
  parameter int AD_W    = 32,
  parameter int LAPSE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AD_W-1:0]     req_addr,
  input  logic [AD_W/8-1:0]   req_be,
  input  logic [AD_W-1:0]     req_wdata,
  input  logic [LAPSE_W-1:0]  cfg_addr_lapse,
  input  logic [LAPSE_W-1:0]  cfg_strobe_lapse,
  input  logic [LAPSE_W-1:0]  cfg_gap_lapse,
  output logic                rsp_valid,
  output logic                rsp_abort,
  output logic [AD_W-1:0]     rsp_rdata,
  output logic                bus_hold,
  input  logic                bus_hlda,
  output logic                bus_ale,
  output logic                bus_rd_n,
  output logic                bus_wr_n,
  output logic [AD_W/8-1:0]   bus_be,
  output logic                bus_cmd_oe,
  output logic [AD_W-1:0]     bus_ad_out,
  output logic                bus_ad_oe,
  input  logic [AD_W-1:0]     bus_ad_in
);

  localparam int BE_W = AD_W / 8;

  extbus_pkg::bus_state_e state;
  logic accept, capture, write_q, park;

  extbus_seq #(.LAPSE_W(LAPSE_W)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .cfg_addr_lapse   (cfg_addr_lapse),
    .cfg_strobe_lapse (cfg_strobe_lapse),
    .cfg_gap_lapse    (cfg_gap_lapse),
    .hlda_i           (bus_hlda),
    .req_ready        (req_ready),
    .accept_o         (accept),
    .capture_o        (capture),
    .write_o          (write_q),
    .park_o           (park),
    .state_o          (state),
    .rsp_valid_o      (rsp_valid),
    .rsp_abort_o      (rsp_abort)
  );

  extbus_pins #(.AD_W(AD_W), .BE_W(BE_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .write_q    (write_q),
    .park       (park),
    .state      (state),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .bus_ad_in  (bus_ad_in),
    .bus_hold   (bus_hold),
    .bus_cmd_oe (bus_cmd_oe),
    .bus_ale    (bus_ale),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_be     (bus_be),
    .bus_ad_out (bus_ad_out),
    .bus_ad_oe  (bus_ad_oe),
    .rdata      (rsp_rdata)
  );

  // R9: nobody owns the bus, so everything floats
  a_r9_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_hold && !bus_hlda && !$past(bus_hlda)) |-> (!bus_cmd_oe && !bus_ad_oe));

  // R2: the requester is never offered a slot while the bus is requested
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_hold);

  // R4: address survives the falling edge of the latch strobe by one cycle
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_ale) && bus_hold) |-> (bus_ad_oe && bus_ad_out == $past(bus_ad_out)));

  // R5: write data leads the write strobe
  a_r5_wdata_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $past(bus_ad_oe && bus_wr_n && !bus_ale));

  // R7: normal completion leaves the bus parked
  a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_abort) |-> (!bus_hold && bus_cmd_oe && !bus_ad_oe && bus_rd_n && bus_wr_n && !bus_ale));

  // R10: a dropped transfer releases everything at once
  a_r10_abort_float: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_abort) |-> (!bus_hold && !bus_cmd_oe && !bus_ad_oe && $past(!bus_hlda)));

endmodule

// File: tb/test_extbus_master.sv
module test_extbus_master;

  localparam int CLK_PERIOD = 10;
  localparam int AD_W = 32;
  localparam int BE_W = AD_W / 8;
  localparam int LW = 4;

  localparam int PH_CMD = 0, PH_ADDR = 1, PH_ALE = 2, PH_AHLD = 3,
                 PH_WLD = 4, PH_STB = 5, PH_TAIL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AD_W-1:0] req_addr = '0, req_wdata = '0;
  logic [BE_W-1:0] req_be = '0;
  logic [LW-1:0] cfg_al = '0, cfg_el = '0, cfg_bl = '0;
  logic rsp_valid, rsp_abort;
  logic [AD_W-1:0] rsp_rdata;
  logic bus_hold, bus_hlda = 1'b0, bus_ale, bus_rd_n, bus_wr_n, bus_cmd_oe, bus_ad_oe;
  logic [BE_W-1:0] bus_be;
  logic [AD_W-1:0] bus_ad_out, bus_ad_in = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  extbus_master #(.AD_W(AD_W), .LAPSE_W(LW)) i_extbus_master (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_be (req_be), .req_wdata (req_wdata),
    .cfg_addr_lapse (cfg_al), .cfg_strobe_lapse (cfg_el), .cfg_gap_lapse (cfg_bl),
    .rsp_valid (rsp_valid), .rsp_abort (rsp_abort), .rsp_rdata (rsp_rdata),
    .bus_hold (bus_hold), .bus_hlda (bus_hlda), .bus_ale (bus_ale),
    .bus_rd_n (bus_rd_n), .bus_wr_n (bus_wr_n), .bus_be (bus_be),
    .bus_cmd_oe (bus_cmd_oe), .bus_ad_out (bus_ad_out), .bus_ad_oe (bus_ad_oe),
    .bus_ad_in (bus_ad_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int phase_at(int i, int al, int el, bit w);
    int j;
    if (i == 0) return PH_CMD;
    if (i == 1) return PH_ADDR;
    if (i < 3 + al) return PH_ALE;
    if (i == 3 + al) return PH_AHLD;
    j = 4 + al;
    if (w) begin
      if (i == j) return PH_WLD;
      j++;
    end
    if (i < j + el + 1) return PH_STB;
    return PH_TAIL;
  endfunction

  function automatic int xfer_len(int al, int el, bit w);
    return 6 + al + el + (w ? 1 : 0);
  endfunction

  function automatic string phase_tag(int ph, bit w);
    case (ph)
      PH_CMD, PH_ADDR, PH_ALE: return "R3";
      PH_AHLD: return "R4";
      PH_STB:  return w ? "R5" : "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic run_txn(input bit w, input logic [31:0] addr, input logic [31:0] wdata,
                         input logic [31:0] rdval, input logic [3:0] be,
                         input int al, input int el, input int bl, input int gd,
                         input int abort_at, input int release_at);
    bit aborted = 0;
    int len;
    @(negedge clk);
    check("R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = w; req_addr = addr; req_wdata = wdata; req_be = be;
    cfg_al = LW'(al); cfg_el = LW'(el); cfg_bl = LW'(bl);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~addr; req_wdata = ~wdata; req_be = ~be;
    cfg_al = LW'($urandom); cfg_el = LW'($urandom); cfg_bl = LW'($urandom); // R12
    check("R2 hold after accept", bus_hold, 1);
    check("R2 ready low when busy", req_ready, 0);
    if (bus_hlda) begin
      check("R8 park continues into request", bus_cmd_oe, 1);
    end else begin
      for (int g = 0; g < gd; g++) begin
        check("R3 nothing driven before grant", bus_cmd_oe, 0);
        check("R3 hold waits for grant", bus_hold, 1);
        @(negedge clk);
      end
      bus_hlda = 1'b1;
    end
    @(negedge clk);
    len = xfer_len(al, el, w);
    for (int i = 0; i < len; i++) begin
      int ph;
      string t;
      ph = phase_at(i, al, el, w);
      t = phase_tag(ph, w);
      check({t, " hold"}, bus_hold, 1);
      check({t, " cmd_oe"}, bus_cmd_oe, 1);
      check({t, " be"}, bus_be, be);
      check({t, " ale"}, bus_ale, ph == PH_ALE);
      check({t, " rd_n"}, bus_rd_n, !(ph == PH_STB && !w));
      check({t, " wr_n"}, bus_wr_n, !(ph == PH_STB && w));
      check({t, " ad_oe"}, bus_ad_oe,
            (ph == PH_ADDR || ph == PH_ALE || ph == PH_AHLD) ||
            (w && (ph == PH_WLD || ph == PH_STB || ph == PH_TAIL)));
      if (ph == PH_ADDR || ph == PH_ALE || ph == PH_AHLD) check({t, " address"}, bus_ad_out, addr);
      else if (w && ph != PH_CMD) check({t, " write data"}, bus_ad_out, wdata);
      if (ph == PH_STB && !w)
        bus_ad_in = (phase_at(i + 1, al, el, w) == PH_TAIL) ? rdval : ~rdval;
      if (i == abort_at) begin
        bus_hlda = 1'b0;
        aborted = 1;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    if (aborted) begin
      check("R10 hold drops", bus_hold, 0);
      check("R10 cmd floats", bus_cmd_oe, 0);
      check("R10 ad floats", bus_ad_oe, 0);
      check("R10 rsp_valid", rsp_valid, 1);
      check("R10 rsp_abort", rsp_abort, 1);
    end else begin
      check("R7 hold drops", bus_hold, 0);
      check("R7 parked cmd_oe", bus_cmd_oe, 1);
      check("R7 parked ale", bus_ale, 0);
      check("R7 parked strobes", {bus_rd_n, bus_wr_n}, 2'b11);
      check("R7 parked be", bus_be, 0);
      check("R7 parked ad_oe", bus_ad_oe, 0);
      check("R7 rsp_valid", rsp_valid, 1);
      check("R7 rsp_abort", rsp_abort, 0);
      if (!w) check("R6 read data", rsp_rdata, rdval);
    end
    for (int k = 0; k <= bl + 1; k++) begin
      bit exp_oe;
      exp_oe = !aborted && !(release_at >= 0 && k > release_at);
      check(exp_oe ? "R8 parked" : "R9 floating", bus_cmd_oe, exp_oe);
      check("R9 ad floating in gap", bus_ad_oe, 0);
      check("R11 hold low in gap", bus_hold, 0);
      check("R11 ready", req_ready, k == bl + 1);
      if (k > 0) check("R7 single pulse", rsp_valid, 0);
      if (!aborted && k == release_at) bus_hlda = 1'b0;
      if (k <= bl) @(negedge clk);
    end
    if (aborted) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R10 no reissue", bus_hold, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    check("R1 hold in reset", bus_hold, 0);
    check("R1 cmd_oe in reset", bus_cmd_oe, 0);
    check("R1 ad_oe in reset", bus_ad_oe, 0);
    check("R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 hold after reset", bus_hold, 0);

    // directed corners
    run_txn(1, 32'h1000_0040, 32'hCAFE_0001, 0, 4'hF, 0, 0, 0, 0, -1, 0);
    run_txn(0, 32'h2000_0080, 0, 32'h1234_5678, 4'h3, 0, 0, 0, 2, -1, -1);
    run_txn(1, 32'h3000_00C0, 32'hBEEF_0002, 0, 4'h5, 3, 2, 1, 0, -1, 1);
    run_txn(0, 32'h4000_0100, 0, 32'h8765_4321, 4'hA, 15, 15, 15, 1, -1, 5);
    run_txn(1, 32'h5000_0140, 32'h0BAD_0003, 0, 4'hC, 2, 1, 2, 0, 3, -1);
    run_txn(0, 32'h6000_0180, 0, 32'h5555_AAAA, 4'h1, 1, 3, 0, 1, 7, -1);
    run_txn(1, 32'h7000_01C0, 32'h0DD0_0004, 0, 4'h8, 0, 0, 3, 2, 0, -1);

    // random mix
    for (int n = 0; n < 40; n++) begin
      bit w;
      int al, el, bl, ab, rl;
      w  = 1'($urandom);
      al = int'($urandom_range(0, 7));
      el = int'($urandom_range(0, 7));
      bl = int'($urandom_range(0, 5));
      ab = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, xfer_len(al, el, w) - 1)) : -1;
      rl = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, bl));
      run_txn(w, $urandom, $urandom, $urandom, 4'($urandom), al, el, bl,
              int'($urandom_range(0, 3)), ab, rl);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule